// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block holds a device's message-signalled interrupt vector table and its pending-bit array behind a 32-bit register port with a 4 KiB window. Software programs each vector's message address, upper address, data and control words. Device logic raises a request carrying a vector index. The block turns each request into a 64-bit address / 32-bit data message on a valid/ready output.

A request on a vector that is in range and marked in use always sets that vector's pending bit first. A scheduler then sends the lowest-index vector that is pending and unmasked whenever the output slot is free and the global enable is high. It clears that vector's pending bit in the same cycle. Because of this, masked vectors, a stalled output and a disabled block all keep requests waiting as pending bits. When software clears a mask through a table write, the waiting message goes out.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Vector v's four dwords sit at byte offsets 16*v + 0 (low address), +4 (upper address), +8 (data) and +12 (control). A dword write to one of them is returned by a later dword read. Read data appears on `rd_data` with `rd_valid` one cycle after `rd_en`. Table offsets for vectors at or above NUM_VEC read as zero and are not stored.
- R2: Bit 0 of a vector's control word is its mask bit; 1 means masked.
- R3: The dword at offset 0x800 reads back the pending bits, with vector v at bit v (bit v%8 of byte 0x800 + v/8). Writes to it are ignored.
- R4: Access size code 2 on `acc_size` is a dword. Codes 0 (byte) and 1 (halfword), and misaligned addresses, make a read return zero and a write have no effect.
- R5: A request whose index is at or above NUM_VEC, or whose vector has its `vec_used` bit low, is discarded: it sets no pending bit and sends no message.
- R6: A request on a masked vector sets its pending bit and sends no message.
- R7: When a table write leaves a pending vector unmasked, its pending bit clears and its message is presented by the second clock edge after the write.
- R8: A message carries address {upper word, low word} and the data word of its vector's entry.
- R9: Reset (synchronous, active high) clears every table word, every pending bit and `msg_valid`.
- R10: While `msg_valid` is high and `msg_ready` is low, the message stays stable. Requests arriving meanwhile become pending bits and are later sent lowest index first, one per accepted transfer.
- R11: While `irq_global_en` is low no new message starts. Requests stay pending and are sent once the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| acc_addr | input | 12 | Byte address in the 4 KiB window |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 dword |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | 5 | Requested vector index |
| vec_used | input | NUM_VEC | Per-vector in-use qualifier |
| irq_global_en | input | 1 | Global message enable |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the fabric |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Every cycle the assertions check four things: a stalled message holds steady, the scheduler grants at most one vector, a masked request leaves its pending bit set, and a discarded request creates no pending bit. They also check that a disabled block starts no message and that sub-dword reads return zero. Only the bench's scenarios can show the rest. These are the byte layout of entries and the pending dword, that ignored writes leave contents untouched, and the replay after an unmasking write with the right address and data. They also cover the lowest-index-first drain order after a stall, and that reset wipes programmed contents.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int WIN_AW   = 12;
  localparam int MAX_VEC  = 32;
  localparam int REQ_IW   = 5;
  localparam logic [WIN_AW-1:0] PEND_OFS = 12'h800;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } ent_word_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int VW = idx_w(NUM_VEC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [WIN_AW-1:0]    acc_addr,
  input  logic [1:0]           acc_size,
  input  logic [31:0]          wr_data,
  input  logic [NUM_VEC-1:0]   pend,
  input  logic [VW-1:0]        sel_vec,
  output logic [31:0]          rd_data,
  output logic                 rd_valid,
  output logic [NUM_VEC-1:0]   mask,
  output logic [63:0]          sel_addr,
  output logic [31:0]          sel_data
);
  logic [31:0] lo_q   [NUM_VEC];
  logic [31:0] hi_q   [NUM_VEC];
  logic [31:0] dat_q  [NUM_VEC];
  logic [31:0] ctl_q  [NUM_VEC];

  logic            dword_ok;
  logic            tbl_hit;
  logic            pend_hit;
  logic [VW-1:0]   ent;
  ent_word_e       wsel;
  logic [31:0]     rd_mux;

  assign dword_ok = (acc_size == SZ_WORD) && (acc_addr[1:0] == 2'b00);
  assign tbl_hit  = !acc_addr[11] && (int'(acc_addr[10:4]) < NUM_VEC);
  assign pend_hit = (acc_addr[11:2] == PEND_OFS[11:2]);
  assign ent      = acc_addr[4 +: VW];
  assign wsel     = ent_word_e'(acc_addr[3:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
        ctl_q[i] <= '0;
      end
    end else if (wr_en && dword_ok && tbl_hit) begin
      unique case (wsel)
        W_ADDR_LO: lo_q[ent]  <= wr_data;
        W_ADDR_HI: hi_q[ent]  <= wr_data;
        W_DATA:    dat_q[ent] <= wr_data;
        W_CTRL:    ctl_q[ent] <= wr_data;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (dword_ok) begin
      if (tbl_hit) begin
        unique case (wsel)
          W_ADDR_LO: rd_mux = lo_q[ent];
          W_ADDR_HI: rd_mux = hi_q[ent];
          W_DATA:    rd_mux = dat_q[ent];
          W_CTRL:    rd_mux = ctl_q[ent];
        endcase
      end else if (pend_hit) begin
        for (int i = 0; i < NUM_VEC; i++) rd_mux[i] = pend[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask
    assign mask[g] = ctl_q[g][0];
  end

  assign sel_addr = {hi_q[sel_vec], lo_q[sel_vec]};
  assign sel_data = dat_q[sel_vec];

  AST_SUBWORD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc_size != SZ_WORD) |=> (rd_valid && rd_data == 32'h0)); // R4
endmodule

// File: rtl/msix_pend_arb.sv
module msix_pend_arb
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int VW = idx_w(NUM_VEC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic [REQ_IW-1:0]    req_vec,
  input  logic [NUM_VEC-1:0]   used,
  input  logic [NUM_VEC-1:0]   mask,
  input  logic                 take,
  output logic [NUM_VEC-1:0]   pend_q,
  output logic                 gnt_vld,
  output logic [VW-1:0]        gnt_vec
);
  logic [NUM_VEC-1:0] set_v;
  logic [NUM_VEC-1:0] elig;
  logic [NUM_VEC-1:0] clr_v;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_set
    assign set_v[g] = req && (req_vec == REQ_IW'(g)) && used[g];
  end

  assign elig = pend_q & ~mask;

  always_comb begin
    gnt_vec = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i]) gnt_vec = VW'(i);
    end
  end

  assign gnt_vld = take && (elig != '0);

  always_comb begin
    clr_v = '0;
    if (gnt_vld) clr_v[gnt_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_v) | set_v;
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_v)); // R10

  AST_MASKED_PENDS: assert property (@(posedge clk) disable iff (rst)
    (req && int'(req_vec) < NUM_VEC && used[req_vec[VW-1:0]] && mask[req_vec[VW-1:0]])
      |=> pend_q[$past(req_vec[VW-1:0])]); // R6

  AST_DROPPED_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (req && (int'(req_vec) >= NUM_VEC || !used[req_vec[VW-1:0]]))
      |=> ((pend_q & ~$past(pend_q)) == '0)); // R5
endmodule

// File: rtl/msix_msg_out.sv
module msix_msg_out (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [63:0] ld_addr,
  input  logic [31:0] ld_data,
  input  logic        ready,
  output logic        slot_free,
  output logic        valid,
  output logic [63:0] addr,
  output logic [31:0] data
);
  assign slot_free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      data  <= ld_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data))); // R10
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [11:0]         acc_addr,
  input  logic [1:0]          acc_size,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  output logic                rd_valid,
  input  logic                irq_req,
  input  logic [4:0]          irq_vec,
  input  logic [NUM_VEC-1:0]  vec_used,
  input  logic                irq_global_en,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [63:0]         msg_addr,
  output logic [31:0]         msg_data
);
  localparam int VW = idx_w(NUM_VEC);

  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] mask;
  logic [VW-1:0]      gnt_vec;
  logic               gnt_vld;
  logic               slot_free;
  logic [63:0]        sel_addr;
  logic [31:0]        sel_data;

  msix_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .wr_data  (wr_data),
    .pend     (pend),
    .sel_vec  (gnt_vec),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .mask     (mask),
    .sel_addr (sel_addr),
    .sel_data (sel_data)
  );

  msix_pend_arb #(.NUM_VEC(NUM_VEC)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (irq_req),
    .req_vec (irq_vec),
    .used    (vec_used),
    .mask    (mask),
    .take    (irq_global_en && slot_free),
    .pend_q  (pend),
    .gnt_vld (gnt_vld),
    .gnt_vec (gnt_vec)
  );

  msix_msg_out u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (gnt_vld),
    .ld_addr   (sel_addr),
    .ld_data   (sel_data),
    .ready     (msg_ready),
    .slot_free (slot_free),
    .valid     (msg_valid),
    .addr      (msg_addr),
    .data      (msg_data)
  );

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!irq_global_en && !msg_valid) |=> !msg_valid); // R11
endmodule

// File: tb/test_msix_vec_ctrl.sv
`timescale 1ns/1ps
module test_msix_vec_ctrl;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [11:0] acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        irq_req;
  logic [4:0]  irq_vec;
  logic [NV-1:0] vec_used;
  logic        irq_global_en;
  logic        msg_valid, msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  msix_vec_ctrl #(.NUM_VEC(NV)) i_msix_vec_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .acc_addr(acc_addr),
    .acc_size(acc_size), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_req(irq_req), .irq_vec(irq_vec), .vec_used(vec_used),
    .irq_global_en(irq_global_en), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  typedef struct packed {
    logic [11:0] a;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] ex;
  } row_t;

  localparam row_t ROWS [9] = '{
    '{12'h000, 2'd2, 32'hFEE0_0000, 32'hFEE0_0000},  // R1 low address
    '{12'h004, 2'd2, 32'h0000_0001, 32'h0000_0001},  // R1 upper address
    '{12'h008, 2'd2, 32'h0000_0041, 32'h0000_0041},  // R1 data
    '{12'h00C, 2'd2, 32'h0000_0001, 32'h0000_0001},  // R2 mask vector 0
    '{12'h070, 2'd2, 32'hAAAA_5555, 32'hAAAA_5555},  // R1 vector 7
    '{12'h074, 2'd0, 32'h1234_5678, 32'h0000_0000},  // R4 byte write ignored
    '{12'h078, 2'd1, 32'h0000_1234, 32'h0000_0000},  // R4 halfword write ignored
    '{12'h080, 2'd2, 32'hDEAD_BEEF, 32'h0000_0000},  // R1 vector 8 out of range
    '{12'h800, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000}   // R3 pending read-only
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; acc_addr = a; acc_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; acc_addr = a; acc_size = sz;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic raise(input logic [4:0] v);
    @(negedge clk);
    irq_req = 1'b1; irq_vec = v;
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; acc_addr = '0; acc_size = 2'd2;
    wr_data = '0; irq_req = 1'b0; irq_vec = '0; vec_used = 8'hDF;
    irq_global_en = 1'b1; msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    chk("R9 msg_valid after reset", 64'(msg_valid), 64'd0);
    reg_rd(12'h000, 2'd2, r); chk("R9 table word after reset", 64'(r), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid), 64'd1);
    reg_rd(12'h800, 2'd2, r); chk("R9 pending after reset", 64'(r), 64'd0);

    for (int i = 0; i < 9; i++) begin
      reg_wr(ROWS[i].a, ROWS[i].sz, ROWS[i].wd);
      reg_rd(ROWS[i].a, 2'd2, r);
      chk($sformatf("R1/R2/R3/R4 row %0d", i), 64'(r), 64'(ROWS[i].ex));
    end

    // R6: masked vector 0 pends, no message
    raise(5'd0);
    repeat (2) @(negedge clk);
    chk("R6 no message when masked", 64'(msg_valid), 64'd0);
    reg_rd(12'h800, 2'd2, r); chk("R6 pending bit set", 64'(r), 64'h1);

    // R7/R8: unmask replays
    reg_wr(12'h00C, 2'd2, 32'h0);
    @(negedge clk);
    chk("R7 replay after unmask", 64'(msg_valid), 64'd1);
    chk("R8 message address", msg_addr, 64'h0000_0001_FEE0_0000);
    chk("R8 message data", 64'(msg_data), 64'h41);
    reg_rd(12'h800, 2'd2, r); chk("R7 pending cleared", 64'(r), 64'h0);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    chk("R10 accepted message leaves", 64'(msg_valid), 64'd0);

    // R5: unused vector 5 and out-of-range 9
    raise(5'd5); raise(5'd9);
    repeat (2) @(negedge clk);
    chk("R5 dropped requests no message", 64'(msg_valid), 64'd0);
    reg_rd(12'h800, 2'd2, r); chk("R5 dropped requests no pending", 64'(r), 64'h0);

    // R4: sub-dword read returns zero
    reg_rd(12'h070, 2'd0, r); chk("R4 byte read zero", 64'(r), 64'd0);

    // R10: stall and drain order
    reg_wr(12'h078, 2'd2, 32'h7);
    reg_wr(12'h038, 2'd2, 32'h3);
    raise(5'd7);
    @(negedge clk);
    chk("R10 first message valid", 64'(msg_valid), 64'd1);
    chk("R8 vector 7 address", msg_addr, 64'h0000_0000_AAAA_5555);
    raise(5'd3); raise(5'd7);
    repeat (2) @(negedge clk);
    chk("R10 stalled data stable", 64'(msg_data), 64'h7);
    reg_rd(12'h800, 2'd2, r); chk("R10/R3 pending while stalled", 64'(r), 64'h88);
    msg_ready = 1'b1;
    @(negedge clk); chk("R10 lowest index drained first", 64'(msg_data), 64'h3);
    @(negedge clk); chk("R10 second drained", 64'(msg_data), 64'h7);
    chk("R10 second valid", 64'(msg_valid), 64'd1);
    @(negedge clk); chk("R10 drained empty", 64'(msg_valid), 64'd0);
    msg_ready = 1'b0;

    // R11: global enable
    irq_global_en = 1'b0;
    raise(5'd3);
    repeat (3) @(negedge clk);
    chk("R11 no message when disabled", 64'(msg_valid), 64'd0);
    reg_rd(12'h800, 2'd2, r); chk("R11 request kept pending", 64'(r), 64'h8);
    irq_global_en = 1'b1;
    @(negedge clk);
    chk("R11 sent after enable", 64'(msg_valid), 64'd1);
    chk("R11 data of vector 3", 64'(msg_data), 64'h3);

    // R9: reset wipes contents
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk("R9 msg_valid cleared", 64'(msg_valid), 64'd0);
    reg_rd(12'h070, 2'd2, r); chk("R9 table cleared", 64'(r), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule